// File: doc/BRIEF.md
# MDIO Station Management Controller

This block is the management-interface master of an Ethernet port. It carries out one read or one write of an external PHY register at a time over the two-wire serial management interface (MDC clock, MDIO data). Software loads a 16-bit data register (for writes), then writes a control word that holds the PHY address, the register address, an operation bit and a go/busy flag. The controller produces MDC from the system clock through a programmable divider, shifts out a clause-22 frame, and clears the busy flag by itself when the frame is done. On a read, the value returned by the PHY is left in the data register.

MDC runs only during a transaction and has a period of 2*(div+1) system clocks. With a 125 MHz system clock, a divider of 24 gives the usual 2.5 MHz. MDIO is split into an output, an output enable and an input, so the pad's tri-state buffer is outside the block.

Top module: `mdio_master`

## Requirements
- R1: Writing the control word with bit 15 set while idle starts a transaction. Bits [9:5] are the PHY address, bits [4:0] the register address and bit 10 the operation (1 = write, 0 = read). `ctl_rdata` shows busy in bit 15 and the last accepted command in bits [10:0].
- R2: Busy stays high for exactly 128*(div+1) system clocks, starting at the clock edge after the accepted control write, and then clears by itself.
- R3: During a transaction MDC has a period of 2*(div+1) system clocks. The divider register holds its reset value of 24 and accepts writes only while idle.
- R4: A write frame is 64 MDC bits. In order, these are 32 ones, start 01, opcode 01, the PHY address MSB first, the register address MSB first, turnaround 10, and then the 16 data bits MSB first. MDIO is driven for all 64 bits.
- R5: A read frame uses opcode 10. MDIO is driven for bits 0..45 and released from the turnaround (bit 46) through bit 63. The 16 data bits (frame bits 48..63) are sampled at the rising MDC edges, MSB first, and appear in `data_rdata` once busy is low.
- R6: MDIO output and output enable change only at a falling edge of MDC, or at the start or end of a transaction.
- R7: While idle, MDC is low and MDIO is released (`mdio_oe` = 0).
- R8: A control-word write that arrives while busy is high is ignored. The frame in progress and the command readback are unchanged.
- R9: A data-register write that arrives while busy is high is ignored. After a write transaction, the data register still holds the value that was sent.
- R10: All 32 PHY addresses and all 32 register addresses are carried in the frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_wdata | input | 16 | Control word: go[15], write[10], phy[9:5], reg[4:0] |
| ctl_rdata | output | 16 | Busy[15] and last command[10:0] |
| data_we | input | 1 | Data-register write strobe |
| data_wdata | input | 16 | Value to send on a write |
| data_rdata | output | 16 | Data register (holds the read result after a read) |
| div_we | input | 1 | Divider write strobe |
| div_wdata | input | DIV_W | New divider value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume that software leaves the divider alone during a frame. The transaction-length and timing checks rely on this. The design enforces it by ignoring divider writes while busy, so the bench's mid-frame register pokes touch only the control and data registers. The assertions also assume that the PHY keeps `mdio_i` steady around each rising MDC edge. The bench's responder keeps to this by changing `mdio_i` only at falling MDC edges. It drives ones outside the data phase, as a pull-up would.

// File: rtl/mdio_pkg.sv
// Package: shared frame geometry and command type for the MDIO master.
// Assumes clause-22 framing with a full 32-bit preamble.
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int TA_IDX     = 46;   // first turnaround bit
    localparam int DATA_IDX   = 48;   // first data bit
    localparam int GO_BIT     = 15;
    localparam int WR_BIT     = 10;

    typedef struct packed {
        logic       wr;
        logic [4:0] phy;
        logic [4:0] rg;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
// Module: MDC generator. Toggles MDC every div+1 system clocks while run is
// high and flags the edge at which MDC rises or falls.
// Assumes div is steady while run is high; MDC is forced low when not running.
module mdio_clkdiv #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    // Half-period boundary and the edge type it produces.
    always_comb begin
        wrap     = run && (cnt == div);
        rise_evt = wrap && !mdc;
        fall_evt = wrap && mdc;
    end

    // Half-period counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// Module: clause-22 frame sequencer. Loads the 64-bit frame at start, moves
// to the next bit on each MDC fall, samples read data on MDC rises.
// Assumes start is only raised while idle and edge strobes come from mdio_clkdiv.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  mdio_cmd_t  cmd,
    input  logic [15:0] wdata,
    input  logic       rise_evt,
    input  logic       fall_evt,
    input  logic       mdio_i,
    output logic       busy,
    output logic       finish,
    output logic       mdio_o,
    output logic       mdio_oe,
    output logic [15:0] rd_data
);
    logic [FRAME_BITS-1:0] sr;
    logic [5:0]            idx;
    logic                  wr_q;
    logic [FRAME_BITS-1:0] frame;

    // Frame image for the command being started.
    always_comb begin
        frame = {32'hFFFF_FFFF, 2'b01, (cmd.wr ? 2'b01 : 2'b10), cmd.phy, cmd.rg,
                 (cmd.wr ? 2'b10 : 2'b11), (cmd.wr ? wdata : 16'hFFFF)};
        finish = busy && fall_evt && (idx == 6'(FRAME_BITS - 1));
        mdio_o = sr[FRAME_BITS-1];
    end

    // Bit sequencing, output enable and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr      <= '0;
            idx     <= '0;
            wr_q    <= 1'b0;
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
            rd_data <= '0;
        end else if (start && !busy) begin
            sr      <= frame;
            idx     <= '0;
            wr_q    <= cmd.wr;
            busy    <= 1'b1;
            mdio_oe <= 1'b1;
        end else if (busy) begin
            if (rise_evt && !wr_q && (idx >= 6'(DATA_IDX)))
                rd_data <= {rd_data[14:0], mdio_i};
            if (finish) begin
                busy    <= 1'b0;
                mdio_oe <= 1'b0;
            end else if (fall_evt) begin
                idx     <= idx + 6'd1;
                sr      <= {sr[FRAME_BITS-2:0], 1'b0};
                mdio_oe <= wr_q || ((idx + 6'd1) < 6'(TA_IDX));
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Module: MDIO station management master (top). Holds the control, data and
// divider registers and connects the MDC generator to the frame sequencer.
// Assumes software polls busy; writes while busy are dropped.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 6,
    parameter int DIV_RST = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [15:0]      ctl_wdata,
    output logic [15:0]      ctl_rdata,
    input  logic             data_we,
    input  logic [15:0]      data_wdata,
    output logic [15:0]      data_rdata,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    mdio_cmd_t        cmd_in;
    mdio_cmd_t        cmd_q;
    logic [15:0]      data_q;
    logic [DIV_W-1:0] div_q;
    logic             busy_w;
    logic             finish_w;
    logic             start_w;
    logic             rise_w;
    logic             fall_w;
    logic [15:0]      rcap_w;
    logic             ctl_unused;

    // Decode the incoming control word.
    always_comb begin
        cmd_in     = '{wr: ctl_wdata[WR_BIT], phy: ctl_wdata[9:5], rg: ctl_wdata[4:0]};
        start_w    = ctl_we && ctl_wdata[GO_BIT] && !busy_w;
        ctl_unused = ^ctl_wdata[14:11];
        ctl_rdata  = {busy_w, 4'b0000, cmd_q};
        data_rdata = data_q;
    end

    // Command and divider registers, written only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            div_q <= DIV_W'(DIV_RST);
        end else begin
            if (start_w) cmd_q <= cmd_in;
            if (div_we && !busy_w) div_q <= div_wdata;
        end
    end

    // Data register: software load while idle, read result at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (finish_w && !cmd_q.wr)
            data_q <= rcap_w;
        else if (data_we && !busy_w)
            data_q <= data_wdata;
    end

    mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_w),
        .div      (div_q),
        .mdc      (mdc),
        .rise_evt (rise_w),
        .fall_evt (fall_w)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .cmd      (cmd_in),
        .wdata    (data_q),
        .rise_evt (rise_w),
        .fall_evt (fall_w),
        .mdio_i   (mdio_i),
        .busy     (busy_w),
        .finish   (finish_w),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_data  (rcap_w)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Module: property checker for mdio_master, bound to every instance.
// Assumes div_q is the divider in force for the current frame.
module mdio_master_chk #(
    parameter int DIV_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             finish,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             ctl_we,
    input logic [15:0]      ctl_wdata,
    input logic [10:0]      cmd_q,
    input logic [15:0]      data_q,
    input logic [DIV_W-1:0] div_q
);
    int unsigned bcnt;

    // Count cycles of the current busy period.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) bcnt <= 0;
        else bcnt <= bcnt + 1;
    end

    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && ctl_wdata[15] && !busy |=> busy);

    assert_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == (32'(div_q) + 32'd1) * 32'd128));

    assert_mdio_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$fell(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc && !mdio_oe);

    assert_ctl_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ctl_we |=> $stable(cmd_q));

    assert_data_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !finish |=> $stable(data_q));
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_w),
    .finish    (finish_w),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .cmd_q     (cmd_q),
    .data_q    (data_q),
    .div_q     (div_q)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
// Bench: sweeps all PHY/register addresses over small dividers with a PHY
// responder; expected frames and timings are computed arithmetically.
module mdio_master_tb;
    localparam int DIV_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_we = 1'b0;
    logic [15:0]      ctl_wdata = '0;
    logic [15:0]      ctl_rdata;
    logic             data_we = 1'b0;
    logic [15:0]      data_wdata = '0;
    logic [15:0]      data_rdata;
    logic             div_we = 1'b0;
    logic [DIV_W-1:0] div_wdata = '0;
    logic             mdc, mdio_o, mdio_oe;
    logic             mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int pos_cnt = 0;
    int last_rise = 0;
    int per_err = 0;
    int cur_div = 0;
    logic [15:0] resp = '0;
    logic [63:0] cap, capoe;

    mdio_master #(.DIV_W(DIV_W)) u_dut (.*);

    always #4 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    // Responder: record bits at MDC rise, check period.
    always @(posedge mdc) begin
        if (pos_cnt > 0 && (cyc - last_rise) != 2 * (cur_div + 1)) per_err++;
        last_rise = cyc;
        if (pos_cnt < 64) begin
            cap[63 - pos_cnt]   = mdio_o;
            capoe[63 - pos_cnt] = mdio_oe;
        end
        pos_cnt++;
    end

    // Responder: present read data after MDC fall.
    always @(negedge mdc) begin
        if (pos_cnt >= 48 && pos_cnt <= 63) mdio_i <= resp[63 - pos_cnt];
        else mdio_i <= 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] rv, input int dv, input bit poke);
        int n;
        logic [63:0] exp_f, exp_oe;
        @(negedge clk);
        div_we = 1'b1; div_wdata = DIV_W'(dv);
        data_we = 1'b1; data_wdata = wd;
        @(negedge clk);
        div_we = 1'b0; data_we = 1'b0;
        cur_div = dv; resp = rv; pos_cnt = 0; per_err = 0;
        ctl_we = 1'b1; ctl_wdata = {1'b1, 4'b0, wr, phy, rg};
        @(negedge clk);
        ctl_we = 1'b0;
        n = 0;
        while (ctl_rdata[15]) begin
            n++;
            if (poke && n == 10) begin
                ctl_we = 1'b1; ctl_wdata = {1'b1, 4'b0, ~wr, ~phy, ~rg};
                data_we = 1'b1; data_wdata = 16'hDEAD;
                div_we = 1'b1; div_wdata = '1;
            end else begin
                ctl_we = 1'b0; data_we = 1'b0; div_we = 1'b0;
            end
            @(negedge clk);
        end
        exp_f  = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, wd};
        exp_oe = wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'b0};
        chk(n == 128 * (dv + 1), "R2 busy length", 64'(n), 64'(128 * (dv + 1)));
        chk(per_err == 0 && pos_cnt == 64, "R3 mdc period/count", 64'(pos_cnt), 64'd64);
        chk(capoe == exp_oe, wr ? "R4 write drive" : "R5 read release", capoe, exp_oe);
        chk((cap & exp_oe) == (exp_f & exp_oe), wr ? "R4 R10 write frame" : "R5 R10 read header",
            cap & exp_oe, exp_f & exp_oe);
        chk(ctl_rdata == {5'b0, wr, phy, rg}, "R1 R8 command readback", 64'(ctl_rdata), 64'({5'b0, wr, phy, rg}));
        chk(data_rdata == (wr ? wd : rv), wr ? "R9 data kept" : "R5 read data",
            64'(data_rdata), 64'(wr ? wd : rv));
        chk(!mdc && !mdio_oe, "R7 idle quiet", {62'b0, mdc, mdio_oe}, 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl_rdata == 16'h0 && data_rdata == 16'h0, "R1 reset registers", {ctl_rdata, data_rdata}, 64'd0);
        chk(!mdc && !mdio_oe, "R7 reset quiet", {62'b0, mdc, mdio_oe}, 64'd0);
        run_txn(1'b1, 5'd1, 5'd0, 16'h8000, 16'h0, 24, 1'b0);
        run_txn(1'b0, 5'd0, 5'd0, 16'h0, 16'hFFFF, 0, 1'b0);
        run_txn(1'b0, 5'd31, 5'd31, 16'h0, 16'h0000, 1, 1'b1);
        run_txn(1'b1, 5'd31, 5'd31, 16'hFFFF, 16'h0, 0, 1'b1);
        for (int p = 0; p < 32; p++) begin
            logic [15:0] w;
            w = 16'(p * 1000) ^ 16'hA5C3;
            run_txn(p[0], 5'(p), ~5'(p), w, ~w, p % 4, (p % 5) == 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule